// File: doc/BRIEF.md
# Paired Base-Register Effective Address Former

This block turns a decoded memory-reference instruction into a two-part address: an effective pointer (which segment is addressed) and an effective internal address (the word offset inside that segment). It holds eight 24-bit base registers, eight 18-bit index registers, the procedure base (the segment now executing) and the instruction counter. The pointer and offset formed for each issued instruction are registered as the data-cycle address.

Each base register can act in one of two ways. It can hold a segment number, or it can hold an offset that is added to the internal address, with three of its bits naming a partner register that supplies the segment number. A type 1 instruction picks a base register through its 3-bit segment tag. A type 0 instruction always addresses the segment that is executing. A transfer loads the instruction counter from the formed offset. A type 1 transfer also moves the formed pointer into the procedure base. The "load pair" operation stores a formed address back into an even/odd pair of base registers. Base-register writes are checked against the execution mode. In slave mode, locked registers and the control bits are protected.

Top module: `seg_addr_former`

## Requirements
- R1: After reset, all base and index registers, the procedure base, the instruction counter, the effective pointer and the effective internal address are zero, and `ea_valid`, `ea_indirect` and `priv_fault` are low.
- R2: In the clock edge that samples `issue` high, `eff_ptr` and `eff_int` are loaded with the address formed for the instruction, and `ea_valid` is high for exactly that following cycle. When `issue` is low, both address outputs hold their values. For type 1 (`ins_type`=1), the register named by `seg_tag` with bit 21 = 1 is an external base: the pointer is its bits 0-17, and the offset contribution from the base is zero.
- R3: For type 1 with the selected register's bit 21 = 0, its bits 0-17 are an internal base p that is added to the offset. The pointer is bits 0-17 of the register that bits 18-20 name.
- R4: Bit 3 of `tag_field` enables indexing, and bits 2-0 pick index register 0-7. For type 1 the internal address is the sign-extended low 15 bits of `ins_addr`, plus the index value when indexing is enabled, plus p.
- R5: For type 0 (`ins_type`=0), the pointer is the procedure base and the internal address is all 18 bits of `ins_addr` plus the index value when indexing is enabled.
- R6: An issued transfer (`op`=1) loads the instruction counter with the formed internal address. For type 1 it also loads the procedure base with the formed pointer. For type 0 the procedure base is unchanged.
- R7: An issued non-transfer (`op`=0, 2 or 3) advances the instruction counter by one. Without `issue`, the instruction counter and the procedure base hold.
- R8: `ea_indirect` is high alongside `ea_valid` exactly when `tag_field` bits 5-4 were 01 (multi-level indexed indirect). Any other code, including 00 (none), gives low.
- R9: In master mode, a base-register write replaces all 24 bits. An index-register write always replaces the 18 bits. A write takes effect after the address for the same cycle has been formed.
- R10: In slave mode, a base-register write is blocked if the target has lock bit 23 set, or if the write would change bit 23 or control bits 18-21. A blocked write leaves the register unchanged, and `priv_fault` is high for the following cycle.
- R11: Load pair (`op`=2) for pair i = `seg_tag` with bit 0 cleared sets bits 0-17 of register i to the formed internal address and bits 0-17 of register i+1 to the formed pointer. Their control bits are kept. In slave mode it is blocked, with `priv_fault` raised, if either register is locked. It is applied after a same-cycle port write.
- R12: All address sums wrap modulo 2^18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = master mode, 0 = slave mode |
| issue | input | 1 | Instruction presented this cycle |
| op | input | 2 | 0 data, 1 transfer taken, 2 load pair, 3 data |
| ins_type | input | 1 | Instruction type bit |
| ins_addr | input | 18 | Address field (low 15 bits signed for type 1) |
| seg_tag | input | 3 | Base register selector (type 1) |
| tag_field | input | 6 | [5:4] indirect type, [3] index enable, [2:0] index register |
| base_we | input | 1 | Base register write strobe |
| base_sel | input | 3 | Base register to write |
| base_wdata | input | 24 | Base register write value |
| xr_we | input | 1 | Index register write strobe |
| xr_sel | input | 3 | Index register to write |
| xr_wdata | input | 18 | Index register write value |
| rd_sel | input | 3 | Base register read selector |
| rd_base | output | 24 | Contents of the selected base register |
| ea_valid | output | 1 | Registered address is fresh |
| ea_indirect | output | 1 | Issued instruction requested indexed indirection |
| eff_ptr | output | 18 | Effective pointer (segment number) |
| eff_int | output | 18 | Effective internal address |
| instr_ctr | output | 18 | Instruction counter |
| proc_base | output | 18 | Procedure base (current segment) |
| priv_fault | output | 1 | One-cycle flag for a blocked slave-mode write |

## Verification
The bench goes after the partner indirection: a design that took the pointer from the selected register itself, or added p for an external base, would give a wrong pointer or offset on type 1 references. It targets sign extension and modulo wrap with negative offsets and all-ones index values; a design that zero-extended or carried into bit 18 would miss the expected internal address. It drives slave writes that touch only the lock bit or only one control bit, and load pairs that overlap a same-cycle port write. A wrong privilege rule or write ordering would show up in the read-back register and in the fault flag. It also issues type 0 transfers, where a design that copied the pointer into the procedure base would jump to the wrong segment.

// File: rtl/seg_addr_former.sv
module seg_addr_former #(
  parameter int AW  = 18,
  parameter int OFW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          issue,
  input  logic [1:0]    op,
  input  logic          ins_type,
  input  logic [AW-1:0] ins_addr,
  input  logic [2:0]    seg_tag,
  input  logic [5:0]    tag_field,
  input  logic          base_we,
  input  logic [2:0]    base_sel,
  input  logic [AW+5:0] base_wdata,
  input  logic          xr_we,
  input  logic [2:0]    xr_sel,
  input  logic [AW-1:0] xr_wdata,
  input  logic [2:0]    rd_sel,
  output logic [AW+5:0] rd_base,
  output logic          ea_valid,
  output logic          ea_indirect,
  output logic [AW-1:0] eff_ptr,
  output logic [AW-1:0] eff_int,
  output logic [AW-1:0] instr_ctr,
  output logic [AW-1:0] proc_base,
  output logic          priv_fault
);
  localparam int NREG = 8;
  localparam int BW   = AW + 6;
  localparam int PL   = AW;
  localparam int EXT  = AW + 3;
  localparam int LCK  = AW + 5;
  localparam logic [1:0] OP_XFER = 2'd1;
  localparam logic [1:0] OP_PAIR = 2'd2;

  logic [BW-1:0] abr [NREG];
  logic [AW-1:0] xr  [NREG];

  wire          sel_ext   = abr[seg_tag][EXT];
  wire [AW-1:0] sel_val   = abr[seg_tag][AW-1:0];
  wire [AW-1:0] partner_v = abr[abr[seg_tag][PL+:3]][AW-1:0];
  wire [AW-1:0] idx_v     = tag_field[3] ? xr[tag_field[2:0]] : '0;
  wire [AW-1:0] sx_ofs    = {{(AW-OFW){ins_addr[OFW-1]}}, ins_addr[OFW-1:0]};
  wire [AW-1:0] p_v       = sel_ext ? '0 : sel_val;
  wire [AW-1:0] ext_v     = ins_type ? (sel_ext ? sel_val : partner_v) : proc_base;
  wire [AW-1:0] int_v     = ins_type ? sx_ofs + idx_v + p_v : ins_addr + idx_v;

  wire [2:0] pi = {seg_tag[2:1], 1'b0};
  wire [2:0] pj = {seg_tag[2:1], 1'b1};
  wire do_pair  = issue && op == OP_PAIR;
  wire pair_blk = do_pair && !master && (abr[pi][LCK] || abr[pj][LCK]);
  wire wr_blk   = base_we && !master &&
                  (abr[base_sel][LCK] || base_wdata[LCK] != abr[base_sel][LCK] ||
                   base_wdata[EXT:PL] != abr[base_sel][EXT:PL]);

  assign rd_base = abr[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        abr[i] <= '0;
        xr[i]  <= '0;
      end
      ea_valid    <= 1'b0;
      ea_indirect <= 1'b0;
      eff_ptr     <= '0;
      eff_int     <= '0;
      instr_ctr   <= '0;
      proc_base   <= '0;
      priv_fault  <= 1'b0;
    end else begin
      ea_valid    <= issue;
      ea_indirect <= issue && tag_field[5:4] == 2'b01;
      priv_fault  <= wr_blk || pair_blk;
      if (issue) begin
        eff_ptr <= ext_v;
        eff_int <= int_v;
        if (op == OP_XFER) begin
          instr_ctr <= int_v;
          if (ins_type) proc_base <= ext_v;
        end else begin
          instr_ctr <= instr_ctr + 1'b1;
        end
      end
      if (base_we && !wr_blk) abr[base_sel] <= base_wdata;
      if (do_pair && !pair_blk) begin
        abr[pi][AW-1:0] <= int_v;
        abr[pj][AW-1:0] <= ext_v;
      end
      if (xr_we) xr[xr_sel] <= xr_wdata;
    end
  end
endmodule

// File: rtl/seg_addr_former_chk.sv
module seg_addr_former_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master,
  input logic          issue,
  input logic [1:0]    op,
  input logic          ins_type,
  input logic          ea_valid,
  input logic          ea_indirect,
  input logic [AW-1:0] eff_ptr,
  input logic [AW-1:0] eff_int,
  input logic [AW-1:0] instr_ctr,
  input logic [AW-1:0] proc_base,
  input logic          priv_fault
);
  assert_valid_follows_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ea_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !ea_valid);
  assert_type0_pointer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !ins_type) |=> eff_ptr == $past(proc_base));
  assert_xfer_loads_ic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 2'd1) |=> instr_ctr == eff_int);
  assert_type0_xfer_keeps_pbr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 2'd1 && !ins_type) |=> $stable(proc_base));
  assert_seq_ic_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op != 2'd1) |=> instr_ctr == AW'($past(instr_ctr) + 1'b1));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(instr_ctr) && $stable(proc_base)));
  assert_indirect_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ea_indirect |-> ea_valid);
  assert_master_never_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    master |=> !priv_fault);
  assert_fault_from_slave_R10: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> $past(!master));
endmodule

bind seg_addr_former seg_addr_former_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .issue(issue), .op(op),
  .ins_type(ins_type), .ea_valid(ea_valid), .ea_indirect(ea_indirect),
  .eff_ptr(eff_ptr), .eff_int(eff_int), .instr_ctr(instr_ctr),
  .proc_base(proc_base), .priv_fault(priv_fault)
);

// File: tb/sim_seg_addr_former.sv
module sim_seg_addr_former;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, issue = 1'b0, ins_type = 1'b0;
  logic [1:0] op = '0;
  logic [17:0] ins_addr = '0;
  logic [2:0] seg_tag = '0;
  logic [5:0] tag_field = '0;
  logic base_we = 1'b0, xr_we = 1'b0;
  logic [2:0] base_sel = '0, xr_sel = '0, rd_sel = '0;
  logic [23:0] base_wdata = '0;
  logic [17:0] xr_wdata = '0;
  logic [23:0] rd_base;
  logic ea_valid, ea_indirect, priv_fault;
  logic [17:0] eff_ptr, eff_int, instr_ctr, proc_base;

  int tests = 0, fails = 0;

  logic [23:0] m_abr [8];
  logic [17:0] m_xr [8];
  logic [17:0] m_pbr, m_ic, m_ep, m_ei;
  logic m_val, m_ind, m_flt;

  always #(CLK_NS/2) clk = ~clk;

  seg_addr_former u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .issue(issue), .op(op),
    .ins_type(ins_type), .ins_addr(ins_addr), .seg_tag(seg_tag), .tag_field(tag_field),
    .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
    .xr_we(xr_we), .xr_sel(xr_sel), .xr_wdata(xr_wdata), .rd_sel(rd_sel),
    .rd_base(rd_base), .ea_valid(ea_valid), .ea_indirect(ea_indirect),
    .eff_ptr(eff_ptr), .eff_int(eff_int), .instr_ctr(instr_ctr),
    .proc_base(proc_base), .priv_fault(priv_fault));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    issue = 1'b0; op = '0; base_we = 1'b0; xr_we = 1'b0; tag_field = '0;
  endtask

  task automatic tick();
    logic [23:0] r;
    logic [17:0] ext, p, idx, ei;
    logic wb, lb, lp;
    logic [2:0] pi;
    r = m_abr[seg_tag];
    idx = tag_field[3] ? m_xr[tag_field[2:0]] : 18'd0;
    if (ins_type) begin
      if (r[21]) begin ext = r[17:0]; p = 18'd0; end
      else begin ext = m_abr[r[20:18]][17:0]; p = r[17:0]; end
      ei = 18'($signed(ins_addr[14:0]) + int'(idx) + int'(p));
    end else begin
      ext = m_pbr;
      ei = 18'(int'(ins_addr) + int'(idx));
    end
    wb = base_we && !master && (m_abr[base_sel][23] || base_wdata[23] != m_abr[base_sel][23]
         || base_wdata[21:18] != m_abr[base_sel][21:18]);
    lp = issue && op == 2'd2;
    pi = {seg_tag[2:1], 1'b0};
    lb = lp && !master && (m_abr[pi][23] || m_abr[pi + 3'd1][23]);
    m_val = issue;
    m_ind = issue && tag_field[5:4] == 2'b01;
    m_flt = wb || lb;
    if (issue) begin
      m_ep = ext; m_ei = ei;
      if (op == 2'd1) begin
        m_ic = ei;
        if (ins_type) m_pbr = ext;
      end else m_ic = m_ic + 18'd1;
    end
    if (base_we && !wb) m_abr[base_sel] = base_wdata;
    if (lp && !lb) begin
      m_abr[pi][17:0] = ei;
      m_abr[pi + 3'd1][17:0] = ext;
    end
    if (xr_we) m_xr[xr_sel] = xr_wdata;
    @(posedge clk);
    #1;
    chk("R2 valid", 32'(ea_valid), 32'(m_val));
    chk("R2 R3 R5 pointer", 32'(eff_ptr), 32'(m_ep));
    chk("R3 R4 R5 R12 internal address", 32'(eff_int), 32'(m_ei));
    chk("R6 R7 instruction counter", 32'(instr_ctr), 32'(m_ic));
    chk("R6 procedure base", 32'(proc_base), 32'(m_pbr));
    chk("R8 indirect", 32'(ea_indirect), 32'(m_ind));
    chk("R10 fault", 32'(priv_fault), 32'(m_flt));
    chk("R9 R10 R11 base readback", 32'(rd_base), 32'(m_abr[rd_sel]));
  endtask

  task automatic wbase(input logic m, input logic [2:0] s, input logic [23:0] d);
    idle(); master = m; base_we = 1'b1; base_sel = s; base_wdata = d; rd_sel = s; tick();
  endtask

  task automatic wxr(input logic [2:0] s, input logic [17:0] d);
    idle(); xr_we = 1'b1; xr_sel = s; xr_wdata = d; tick();
  endtask

  task automatic ins(input logic [1:0] o, input logic t, input logic [2:0] sg,
                     input logic [17:0] a, input logic [5:0] tg);
    idle(); issue = 1'b1; op = o; ins_type = t; seg_tag = sg; ins_addr = a; tag_field = tg; tick();
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_abr[i] = '0; m_xr[i] = '0; end
    m_pbr = '0; m_ic = '0; m_ep = '0; m_ei = '0; m_val = 0; m_ind = 0; m_flt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 valid", 32'(ea_valid), 0);
    chk("R1 indirect", 32'(ea_indirect), 0);
    chk("R1 fault", 32'(priv_fault), 0);
    chk("R1 pointer", 32'(eff_ptr), 0);
    chk("R1 internal", 32'(eff_int), 0);
    chk("R1 counter", 32'(instr_ctr), 0);
    chk("R1 procedure base", 32'(proc_base), 0);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i); #1;
      chk("R1 base register", 32'(rd_base), 0);
    end
    rst_n = 1'b1;
    // R9 master writes: abr0 external seg 5, abr2 internal p=100 -> abr3, abr3 external seg 7
    wbase(1, 3'd0, 24'h200005);
    wbase(1, 3'd3, 24'h200007);
    wbase(1, 3'd2, {3'b000, 3'd3, 18'd100});
    wxr(3'd1, 18'd10);
    ins(2'd0, 1, 3'd0, 18'h7FFD, 6'b001001);   // R2 R4: -3 + 10 -> 7, ptr 5
    ins(2'd0, 1, 3'd2, 18'd20, 6'b000000);     // R3: 120, ptr 7
    ins(2'd0, 1, 3'd2, 18'd20, 6'b011001);     // R8 indirect, R4 index
    ins(2'd0, 1, 3'd2, 18'd20, 6'b100000);     // R8 other code
    ins(2'd1, 1, 3'd2, 18'd4, 6'b000000);      // R6 type 1 transfer
    ins(2'd0, 0, 3'd0, 18'h3FFF0, 6'b001001);  // R5 type 0
    ins(2'd1, 0, 3'd0, 18'd55, 6'b000000);     // R6 type 0 transfer keeps pbr
    idle(); tick(); tick();                    // R7 hold
    wxr(3'd6, 18'h3FFFF);
    ins(2'd0, 0, 3'd0, 18'd2, 6'b001110);      // R12 wrap type 0
    ins(2'd0, 1, 3'd0, 18'h4000, 6'b001110);   // R12 negative offset wrap
    // R10 slave protection
    wbase(1, 3'd4, 24'h800009);                // locked, master
    wbase(0, 3'd4, 24'h800011);                // blocked: locked
    wbase(0, 3'd5, 24'h000044);                // allowed: value only
    wbase(0, 3'd5, 24'h040044);                // blocked: control bit 18
    wbase(0, 3'd5, 24'h800044);                // blocked: lock bit
    wbase(0, 3'd5, 24'h400055);                // allowed: spare bit 22
    // R11 load pair
    idle(); master = 0; issue = 1; op = 2'd2; ins_type = 1; seg_tag = 3'd3;
    ins_addr = 18'd33; rd_sel = 3'd2; tick();
    idle(); rd_sel = 3'd3; tick();
    idle(); master = 0; issue = 1; op = 2'd2; ins_type = 1; seg_tag = 3'd5;
    ins_addr = 18'd1; rd_sel = 3'd4; tick();  // blocked: abr4 locked
    idle(); master = 1; issue = 1; op = 2'd2; ins_type = 0; seg_tag = 3'd4;
    ins_addr = 18'd77; base_we = 1; base_sel = 3'd5; base_wdata = 24'h2ABCDE;
    rd_sel = 3'd5; tick();                     // R11 overlap with port write
    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      master = ($urandom_range(0, 9) < 6);
      issue = ($urandom_range(0, 3) != 0);
      op = 2'($urandom);
      ins_type = 1'($urandom);
      ins_addr = 18'($urandom);
      seg_tag = 3'($urandom);
      tag_field = 6'($urandom);
      base_we = ($urandom_range(0, 3) == 0);
      base_sel = 3'($urandom);
      base_wdata = ($urandom_range(0, 1) == 0) ? {m_abr[base_sel][23:18], 18'($urandom)}
                                               : 24'($urandom);
      xr_we = ($urandom_range(0, 4) == 0);
      xr_sel = 3'($urandom);
      xr_wdata = ($urandom_range(0, 3) == 0) ? 18'h3FFFF : 18'($urandom);
      rd_sel = 3'($urandom);
      tick();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule